// File: doc/BRIEF.md
# Serial Port Byte Queues with Threshold Interrupts

This block sits between a serial shifter and a host register port. It keeps two 32-entry queues. The receive queue stores each incoming character together with four error flags. The transmit queue holds bytes that the host wrote, until the shifter takes them. The host sets a fill threshold for each direction and enables interrupt sources one by one. It acknowledges events by writing ones into a status register.

Four events can raise the interrupt:
- The receive queue fills up to its threshold.
- The transmit queue drains down to its threshold. This threshold counts bytes still queued, not free slots.
- Received data has sat unread for eight character periods. This catches a short burst that never reaches the receive threshold.
- A break is reported.

The block contains no shifter, parity logic or baud generator. Characters arrive on a one-cycle push strobe, and a separate strobe marks each character period.

Top module: `serial_fifo_ctrl`

Register map (3-bit address; `reg_rdata` is combinational from `reg_addr`):

| Address | Name | Access | Contents |
|---|---|---|---|
| 0 | TXDATA | write | Bits [7:0] are queued for transmit. Reads return 0. |
| 1 | RXDATA | read | Returns the receive head word and pops it. |
| 2 | LEVELS | read/write | Bits [5:0] are the receive threshold. Bits [13:8] are the transmit threshold. |
| 3 | IRQEN | read/write | Bits [3:0] are the per-source enables. |
| 4 | STATUS | read, write-one-to-clear | Bits [3:0] are sticky: bit0 transmit-ready, bit1 receive-ready, bit2 aging, bit3 break. Bit 8 is the live data-ready bit. |
| 5 | FILL | read | Bits [5:0] are the receive count. Bits [13:8] are the transmit count. |

## Requirements
- R1: Each queue holds up to 32 entries and releases them in arrival order. FILL (address 5) reports the receive count in bits [5:0] and the transmit count in bits [13:8].
- R2: A receive word has data in bits [7:0], frame error in bit 8, parity error in bit 9, overrun in bit 10 and break in bit 11. A read of RXDATA (address 1) returns the head word and pops it. A read of an empty queue returns 0 and pops nothing.
- R3: A receive push while the receive queue is full is dropped. The next stored word then carries overrun (bit 10) set.
- R4: A TXDATA (address 0) write while the transmit queue is full is ignored. `tx_avail` and `tx_byte` present the head byte, and `tx_pop` removes it.
- R5: STATUS bit1 sets one cycle after the receive count is at or above the receive threshold (LEVELS bits [5:0], reset 24).
- R6: STATUS bit0 sets one cycle after the transmit count is at or below the transmit threshold (LEVELS bits [13:8], reset 8).
- R7: An aging counter advances on `char_tick` while the receive queue is non-empty. Any receive push and any accepted pop return it to zero, and it stays at zero while the queue is empty. STATUS bit2 sets when the counter reaches 8.
- R8: STATUS bit3 sets one cycle after any receive push with `rx_break` high.
- R9: STATUS bits [3:0] are sticky and are cleared by writing ones to address 4. If a bit's set condition holds in the same cycle as the clear, the set wins.
- R10: STATUS bit 8 reads 1 exactly while the receive queue is non-empty.
- R11: `irq` is high while any STATUS bit [3:0] is set together with its IRQEN (address 3) bit.
- R12: After reset both queues are empty, LEVELS reads 0x0818, IRQEN reads 0 and STATUS reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 1) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| rx_push | input | 1 | One received character is present this cycle |
| rx_data | input | 8 | Received character |
| rx_frame_err | input | 1 | Frame error for this character |
| rx_parity_err | input | 1 | Parity error for this character |
| rx_break | input | 1 | Break seen with this character |
| char_tick | input | 1 | One-cycle strobe per character period |
| tx_pop | input | 1 | The shifter takes the head byte |
| tx_byte | output | 8 | Head byte of the transmit queue (0 when empty) |
| tx_avail | output | 1 | The transmit queue is non-empty |

## Verification
A queue pointer or count that goes wrong shows up at once in FILL and in the data-ready bit. It then shows as a wrong `tx_byte` or RXDATA word on the next pop. A wrong aging count shows as STATUS bit2 setting one or more character periods early or late. A lost pending-overrun state shows as a clean word where bit 10 was expected. The reference model is compared against `irq`, `tx_avail`, `tx_byte` and the addressed read value on every clock. Any such fault is therefore reported in the cycle it first reaches a port.

// File: rtl/serial_fifo_pkg.sv
// Shared constants and types for the serial byte-queue block.
// Assumes an 8-bit character and a 3-bit register address space.
package serial_fifo_pkg;
    localparam int CHAR_W = 8;
    localparam int ADDR_W = 3;
    localparam int REG_W  = 16;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_TXDATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_RXDATA = 3'd1;
    localparam logic [ADDR_W-1:0] A_LEVELS = 3'd2;
    localparam logic [ADDR_W-1:0] A_IRQEN  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;
    localparam logic [ADDR_W-1:0] A_FILL   = 3'd5;

    // Interrupt source bit positions
    localparam int SRC_TX  = 0;
    localparam int SRC_RX  = 1;
    localparam int SRC_AGE = 2;
    localparam int SRC_BRK = 3;
    localparam int N_SRC   = 4;

    // Bit position of the live data-ready flag in STATUS
    localparam int DREADY_BIT = 8;

    // Stored receive word, most significant field first
    typedef struct packed {
        logic              brk;
        logic              ovr;
        logic              par;
        logic              frm;
        logic [CHAR_W-1:0] data;
    } rx_word_t;
endpackage

// File: rtl/byte_fifo.sv
// Generic first-in first-out queue with a fill count.
// Assumes DEPTH is a power of two. A push into a full queue and a pop
// from an empty queue are both dropped. Fullness is judged on the
// count at the start of the cycle.
module byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    fill;
    logic             do_push;
    logic             do_pop;

    assign full    = (fill == CW'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign count   = fill;
    assign dout    = mem[rd_ptr];

    // Store an accepted entry
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Advance the pointers and the fill count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            fill <= fill + CW'(do_push) - CW'(do_pop);
        end
    end

    assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(count));

    assert_empty_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (count == '0));
endmodule

// File: rtl/rx_age_timer.sv
// Counts character periods during which unread receive data sits idle.
// Emits a one-cycle pulse when the count reaches LIMIT, then saturates.
// Assumes 'restart' marks any receive push or accepted pop.
module rx_age_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic empty,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt;

    assign expired = tick && !restart && !empty && (cnt == TW'(LIMIT - 1));

    // Idle period counter; cleared by activity or an empty queue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || empty) begin
            cnt <= '0;
        end else if (tick && (cnt != TW'(LIMIT))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_zero_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (cnt == '0));

    assert_single_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !expired);
endmodule

// File: rtl/irq_status.sv
// Sticky event bits with write-one-to-clear and per-source enables.
// Level sources re-set while their condition holds. A set wins over a
// clear in the same cycle. The thresholds are compared with registered
// counts.
module irq_status
    import serial_fifo_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    rx_count,
    input  logic [CW-1:0]    tx_count,
    input  logic [CW-1:0]    rx_thr,
    input  logic [CW-1:0]    tx_thr,
    input  logic             age_evt,
    input  logic             brk_evt,
    input  logic [N_SRC-1:0] clr_mask,
    input  logic [N_SRC-1:0] en,
    output logic [N_SRC-1:0] sticky,
    output logic             irq
);
    logic [N_SRC-1:0] set_v;

    // Gather this cycle's set conditions
    always_comb begin
        set_v          = '0;
        set_v[SRC_TX]  = (tx_count <= tx_thr);
        set_v[SRC_RX]  = (rx_count >= rx_thr);
        set_v[SRC_AGE] = age_evt;
        set_v[SRC_BRK] = brk_evt;
    end

    // Sticky register: clear by mask, then OR in new events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= '0;
        end else begin
            sticky <= (sticky & ~clr_mask) | set_v;
        end
    end

    assign irq = |(sticky & en);

    assert_brk_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> sticky[SRC_BRK]);

    assert_age_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        age_evt |=> sticky[SRC_AGE]);

    assert_rx_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count >= rx_thr) |=> sticky[SRC_RX]);

    assert_tx_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= tx_thr) |=> sticky[SRC_TX]);

    assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);
endmodule

// File: rtl/serial_fifo_ctrl.sv
// Top level: register decode, receive/transmit queues, aging timer and
// interrupt status. Assumes one host access per cycle; the read data
// is combinational from the address. A read of RXDATA pops on the same
// edge that ends the read cycle.
module serial_fifo_ctrl
    import serial_fifo_pkg::*;
#(
    parameter int FIFO_DEPTH   = 32,
    parameter int RX_THR_RESET = 24,
    parameter int TX_THR_RESET = 8,
    parameter int AGE_CHARS    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                irq,
    input  logic                rx_push,
    input  logic [CHAR_W-1:0]   rx_data,
    input  logic                rx_frame_err,
    input  logic                rx_parity_err,
    input  logic                rx_break,
    input  logic                char_tick,
    input  logic                tx_pop,
    output logic [CHAR_W-1:0]   tx_byte,
    output logic                tx_avail
);
    localparam int CW     = $clog2(FIFO_DEPTH) + 1;
    localparam int WORD_W = $bits(rx_word_t);
    localparam int HI_LSB = 8;

    logic [CW-1:0]    rx_thr;
    logic [CW-1:0]    tx_thr;
    logic [N_SRC-1:0] irq_en;
    logic             pend_ovr;

    logic             wr_tx, wr_lvl, wr_en, wr_st, rd_rx;
    logic             rx_full, rx_empty, tx_full, tx_empty;
    logic [CW-1:0]    rx_count, tx_count;
    rx_word_t         in_word;
    rx_word_t         head_word;
    logic [CHAR_W-1:0] tx_head;
    logic             age_evt;
    logic             restart;
    logic [N_SRC-1:0] clr_mask;
    logic [N_SRC-1:0] sticky;
    logic             unused_wdata;

    assign wr_tx  = reg_wr && (reg_addr == A_TXDATA);
    assign wr_lvl = reg_wr && (reg_addr == A_LEVELS);
    assign wr_en  = reg_wr && (reg_addr == A_IRQEN);
    assign wr_st  = reg_wr && (reg_addr == A_STATUS);
    assign rd_rx  = reg_rd && (reg_addr == A_RXDATA);

    assign unused_wdata = ^reg_wdata;

    // Assemble the stored receive word
    always_comb begin
        in_word.brk  = rx_break;
        in_word.ovr  = pend_ovr;
        in_word.par  = rx_parity_err;
        in_word.frm  = rx_frame_err;
        in_word.data = rx_data;
    end

    // Host-programmed thresholds and enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_thr <= CW'(RX_THR_RESET);
            tx_thr <= CW'(TX_THR_RESET);
            irq_en <= '0;
        end else begin
            if (wr_lvl) begin
                rx_thr <= reg_wdata[CW-1:0];
                tx_thr <= reg_wdata[HI_LSB+CW-1:HI_LSB];
            end
            if (wr_en) begin
                irq_en <= reg_wdata[N_SRC-1:0];
            end
        end
    end

    // Remember a dropped character until the next push is stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_ovr <= 1'b0;
        end else if (rx_push) begin
            pend_ovr <= rx_full;
        end
    end

    byte_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .din   (in_word),
        .pop   (rd_rx),
        .dout  (head_word),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    byte_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_tx),
        .din   (reg_wdata[CHAR_W-1:0]),
        .pop   (tx_pop),
        .dout  (tx_head),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    assign restart = rx_push || (rd_rx && !rx_empty);

    rx_age_timer #(.LIMIT(AGE_CHARS)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (char_tick),
        .restart (restart),
        .empty   (rx_empty),
        .expired (age_evt)
    );

    assign clr_mask = wr_st ? reg_wdata[N_SRC-1:0] : '0;

    irq_status #(.CW(CW)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_thr   (rx_thr),
        .tx_thr   (tx_thr),
        .age_evt  (age_evt),
        .brk_evt  (rx_push && rx_break),
        .clr_mask (clr_mask),
        .en       (irq_en),
        .sticky   (sticky),
        .irq      (irq)
    );

    assign tx_avail = !tx_empty;
    assign tx_byte  = tx_empty ? '0 : tx_head;

    // Register read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_RXDATA: if (!rx_empty) reg_rdata[WORD_W-1:0] = head_word;
            A_LEVELS: begin
                reg_rdata[CW-1:0]               = rx_thr;
                reg_rdata[HI_LSB+CW-1:HI_LSB]   = tx_thr;
            end
            A_IRQEN:  reg_rdata[N_SRC-1:0] = irq_en;
            A_STATUS: begin
                reg_rdata[N_SRC-1:0]  = sticky;
                reg_rdata[DREADY_BIT] = !rx_empty;
            end
            A_FILL: begin
                reg_rdata[CW-1:0]             = rx_count;
                reg_rdata[HI_LSB+CW-1:HI_LSB] = tx_count;
            end
            default: reg_rdata = '0;
        endcase
    end

    assert_overrun_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> pend_ovr);

    assert_tx_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && tx_full) |=> (tx_count <= $past(tx_count)));
endmodule

// File: tb/serial_fifo_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model (queues and integers) compared on
// every falling edge against irq, tx_avail, tx_byte and the addressed
// register, plus directed checks with fixed expected values.
module serial_fifo_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd4;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_frame_err = 1'b0, rx_parity_err = 1'b0, rx_break = 1'b0;
    logic        char_tick = 1'b0;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_avail;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_fifo_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .rx_push(rx_push), .rx_data(rx_data),
        .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
        .rx_break(rx_break), .char_tick(char_tick), .tx_pop(tx_pop),
        .tx_byte(tx_byte), .tx_avail(tx_avail)
    );

    // ---------------- reference model ----------------
    bit [11:0] rxq[$];
    bit [7:0]  txq[$];
    int        m_rxthr, m_txthr, m_age, rxn, txn;
    bit [3:0]  m_en, m_st, setv, clr;
    bit        m_pend, rd_ok, pop_ok, restart;

    always @(posedge clk) begin
        if (!rst_n) begin
            rxq.delete(); txq.delete();
            m_rxthr = 24; m_txthr = 8; m_en = 0; m_st = 0; m_age = 0; m_pend = 0;
        end else begin
            rxn = rxq.size(); txn = txq.size();
            rd_ok  = reg_rd && reg_addr == 3'd1 && rxn > 0;
            pop_ok = tx_pop && txn > 0;
            restart = rx_push || rd_ok;
            setv[0] = (txn <= m_txthr);
            setv[1] = (rxn >= m_rxthr);
            setv[2] = char_tick && !restart && rxn > 0 && m_age == 7;
            setv[3] = rx_push && rx_break;
            clr = (reg_wr && reg_addr == 3'd4) ? reg_wdata[3:0] : 4'd0;
            m_st = (m_st & ~clr) | setv;
            if (restart || rxn == 0) m_age = 0;
            else if (char_tick && m_age < 8) m_age = m_age + 1;
            if (rd_ok) void'(rxq.pop_front());
            if (rx_push) begin
                if (rxn < 32) rxq.push_back({rx_break, m_pend, rx_parity_err, rx_frame_err, rx_data});
                m_pend = (rxn >= 32);
            end
            if (pop_ok) void'(txq.pop_front());
            if (reg_wr && reg_addr == 3'd0 && txn < 32) txq.push_back(reg_wdata[7:0]);
            if (reg_wr && reg_addr == 3'd2) begin
                m_rxthr = reg_wdata[5:0]; m_txthr = reg_wdata[13:8];
            end
            if (reg_wr && reg_addr == 3'd3) m_en = reg_wdata[3:0];
        end
    end

    function automatic bit [15:0] model_read(input bit [2:0] a);
        case (a)
            3'd1: return (rxq.size() > 0) ? {4'd0, rxq[0]} : 16'd0;
            3'd2: return {2'd0, 6'(m_txthr), 2'd0, 6'(m_rxthr)};
            3'd3: return {12'd0, m_en};
            3'd4: return {7'd0, rxq.size() > 0, 4'd0, m_st};
            3'd5: return {2'd0, 6'(txq.size()), 2'd0, 6'(rxq.size())};
            default: return 16'd0;
        endcase
    endfunction

    function automatic string tag_of(input bit [2:0] a);
        case (a)
            3'd1: return "R2";
            3'd2: return "R5";
            3'd3: return "R11";
            3'd4: return "R9";
            3'd5: return "R1";
            default: return "R4";
        endcase
    endfunction

    function automatic void chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endfunction

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq == |(m_st & m_en), "R11 irq", irq, |(m_st & m_en));
            chk(tx_avail == (txq.size() > 0), "R4 tx_avail", tx_avail, txq.size() > 0);
            if (txq.size() > 0) chk(tx_byte == txq[0], "R4 tx_byte", tx_byte, txq[0]);
            chk(reg_rdata == model_read(reg_addr), tag_of(reg_addr), reg_rdata, model_read(reg_addr));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- drivers ----------------
    task automatic step();
        @(posedge clk); #1;
        reg_wr = 0; reg_rd = 0; reg_addr = 3'd4; rx_push = 0; rx_break = 0;
        rx_frame_err = 0; rx_parity_err = 0; char_tick = 0; tx_pop = 0;
    endtask

    task automatic hwrite(input bit [2:0] a, input bit [15:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; step();
    endtask

    task automatic rxin(input bit [7:0] d, input bit f, input bit p, input bit b);
        rx_push = 1; rx_data = d; rx_frame_err = f; rx_parity_err = p; rx_break = b; step();
    endtask

    // Read with fixed expected value under a mask; pops when at RXDATA
    task automatic rexp(input bit [2:0] a, input bit [15:0] mask, input bit [15:0] exp, input string tag);
        reg_addr = a; reg_rd = 1;
        @(negedge clk);
        chk((reg_rdata & mask) == exp, tag, reg_rdata & mask, exp);
        step();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin char_tick = 1; step(); end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        // R12 reset values
        rexp(3'd2, 16'hFFFF, 16'h0818, "R12 levels");
        rexp(3'd3, 16'hFFFF, 16'h0000, "R12 irqen");
        rexp(3'd5, 16'hFFFF, 16'h0000, "R12 fill");
        // R9 transmit-ready re-sets after clear (set wins)
        hwrite(3'd4, 16'h000F);
        rexp(3'd4, 16'hFFFF, 16'h0001, "R9 reset after clear");
        // R2 / R10 receive word layout and data-ready
        rxin(8'hA5, 1, 0, 0);
        rxin(8'h3C, 0, 1, 0);
        rexp(3'd4, 16'h0100, 16'h0100, "R10 data ready");
        rexp(3'd1, 16'hFFFF, 16'h01A5, "R2 frame word");
        rexp(3'd1, 16'hFFFF, 16'h023C, "R2 parity word");
        rexp(3'd1, 16'hFFFF, 16'h0000, "R2 empty read");
        rexp(3'd4, 16'h0100, 16'h0000, "R10 data ready low");
        // R7 aging and R11 interrupt gating
        rxin(8'h11, 0, 0, 0);
        hwrite(3'd4, 16'h000F);
        ticks(7);
        rexp(3'd4, 16'h0004, 16'h0000, "R7 before eight");
        ticks(1);
        rexp(3'd4, 16'h0004, 16'h0004, "R7 at eight");
        hwrite(3'd3, 16'h0004);
        @(negedge clk); chk(irq == 1, "R11 aging irq", irq, 1); step();
        hwrite(3'd4, 16'h0004);
        ticks(3);
        @(negedge clk); chk(irq == 0, "R11 cleared irq", irq, 0); step();
        rexp(3'd1, 16'hFFFF, 16'h0011, "R2 stale word");
        hwrite(3'd3, 16'h0000);
        // R5 receive threshold programmed to 4
        hwrite(3'd2, 16'h0804);
        hwrite(3'd4, 16'h000F);
        for (int i = 0; i < 3; i++) rxin(8'(i), 0, 0, 0);
        step();
        rexp(3'd4, 16'h0002, 16'h0000, "R5 below");
        rxin(8'h03, 0, 0, 0);
        step();
        rexp(3'd4, 16'h0002, 16'h0002, "R5 reached");
        for (int i = 0; i < 4; i++) rexp(3'd1, 16'h00FF, 16'(i), "R1 order");
        hwrite(3'd2, 16'h0818);
        // R3 overrun
        for (int i = 0; i < 32; i++) rxin(8'(i + 8'h40), 0, 0, 0);
        rexp(3'd5, 16'h003F, 16'd32, "R1 rx full count");
        rxin(8'hEE, 0, 0, 0);
        rxin(8'hEF, 0, 0, 0);
        rexp(3'd5, 16'h003F, 16'd32, "R3 drop keeps count");
        rexp(3'd1, 16'hFFFF, 16'h0040, "R3 head intact");
        rxin(8'h77, 0, 0, 0);
        for (int i = 0; i < 31; i++) begin reg_addr = 3'd1; reg_rd = 1; step(); end
        rexp(3'd1, 16'hFFFF, 16'h0477, "R3 overrun flag");
        rxin(8'h78, 0, 0, 0);
        rexp(3'd1, 16'hFFFF, 16'h0078, "R3 flag once");
        // R8 break
        hwrite(3'd4, 16'h000F);
        rxin(8'h00, 1, 0, 1);
        rexp(3'd4, 16'h0008, 16'h0008, "R8 break status");
        rexp(3'd1, 16'hFFFF, 16'h0900, "R8 break word");
        // R4 / R6 transmit side
        for (int i = 0; i < 33; i++) hwrite(3'd0, 16'(i + 8'h80));
        rexp(3'd5, 16'hFFFF, 16'h2000, "R4 ignored write");
        for (int i = 0; i < 23; i++) begin tx_pop = 1; step(); end
        hwrite(3'd4, 16'h000F);
        rexp(3'd4, 16'hFFFF, 16'h0000, "R6 above threshold");
        tx_pop = 1; step();
        step();
        rexp(3'd4, 16'hFFFF, 16'h0001, "R6 at threshold");
        @(negedge clk); chk(tx_byte == 8'h98, "R4 head byte", tx_byte, 8'h98); step();
        for (int i = 0; i < 8; i++) begin tx_pop = 1; step(); end
        @(negedge clk); chk(tx_avail == 0, "R4 drained", tx_avail, 0); step();
        repeat (3) step();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule